// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Return-Stack Watermark

This block sits beside a processor core and decides which interrupt, if any, the core should take next. Thirteen request lines are captured into a pending register that software can also set and clear bit by bit. Maskable sources are gated by a mask register and by a global enable. The lowest-numbered eligible source wins, and its index is presented as the vector index. Three sources bypass the mask: reset, emulation and power-down. Power-down still obeys the global enable.

The core acknowledges a presented vector with `ack`. The controller then clears that pending bit, saves the running priority level on an internal 33-entry level stack, and makes the granted source the running level. A return (`pop`) restores the saved level. Subroutine calls (`push`) save the running level without changing it, so the stack fill mirrors the depth of the core's return-address stack. When that fill drops below 3 or climbs above 28, the stack-level source is raised as pending. A nesting control picks one of two policies: handlers run to completion, or a strictly more urgent source may preempt the running one.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After synchronous reset, pending, mask and global enable are all zero, the running level `active_q` is 13 (idle), `stack_fill` is 0 and `irq_valid` is low.
- R2: A request bit that is high at a clock edge sets the matching pending bit. The bit stays set until it is cleared by software or by a grant.
- R3: `pend_set` bits set pending bits and `pend_clr` bits clear them. When a bit is set and cleared in the same cycle (by request, set strobe or watermark on one side, and clear strobe or grant on the other), the set wins.
- R4: Sources 3 to 12 are eligible only when their mask bit is 1 and the global enable is on. A write on `mask_we` loads `mask_wdata` at the next edge.
- R5: Source 0 (reset) and source 2 (emulation) are eligible whenever pending, whatever the mask or the global enable. Source 1 (power-down) ignores the mask but is eligible only while the global enable is on.
- R6: `irq_vec` gives the lowest-numbered eligible source. `irq_valid` is high only when that source may be granted under R8 to R11.
- R7: `gie_on` turns the global enable on and `gie_off` turns it off at the next edge. When both strobes are high in the same cycle, off wins.
- R8: With `nest_en` low, nothing is presented while `active_q` is not 13.
- R9: With `nest_en` high and a handler running, a source is presented only if its index is strictly lower than `active_q`. Otherwise nothing is presented.
- R10: `ack` while `irq_valid` is high is a grant. A grant clears that pending bit, saves `active_q`, loads `irq_vec` into `active_q` and raises `stack_fill` by one. A grant takes precedence over `pop` and `push` in the same cycle.
- R11: If there is no grant, `pop` restores the most recently saved level and lowers the fill. A `pop` at fill 0 is ignored. If there is neither a grant nor a pop, `push` saves `active_q` unchanged and raises the fill. A `push` at fill 33 is ignored, and at fill 33 `irq_valid` stays low.
- R12: When a stack operation moves the fill from 3 or more to below 3, or from 28 or less to above 28, pending bit 3 is set at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | NUM_SRC | Request lines, one per source |
| mask_we | input | 1 | Load the mask register |
| mask_wdata | input | NUM_SRC | New mask value |
| pend_set | input | NUM_SRC | Software set of pending bits |
| pend_clr | input | NUM_SRC | Software clear of pending bits |
| gie_on | input | 1 | Global enable on strobe |
| gie_off | input | 1 | Global enable off strobe |
| nest_en | input | 1 | Allow preemption by a more urgent source |
| ack | input | 1 | Core takes the presented vector |
| push | input | 1 | Subroutine call saves the running level |
| pop | input | 1 | Return restores the saved level |
| irq_valid | output | 1 | A vector is presented |
| irq_vec | output | LVLW | Presented source index |
| mask_q | output | NUM_SRC | Mask register |
| pend_q | output | NUM_SRC | Pending register |
| gie_q | output | 1 | Global enable state |
| active_q | output | LVLW | Running level, NUM_SRC when idle |
| stack_fill | output | FILLW | Number of saved levels |

## Verification
The cases that matter most are the ones where two updates hit the pending register in the same cycle. One is a software clear against a fresh request or software set of the same bit. The other is a grant clearing its own bit while the stack operation from that grant makes bit 3 cross a watermark. The random phase drives sparse set, clear and request vectors that often overlap, with `ack` asserted about half the time. A directed phase pushes the stack to full and pops it to empty, so it crosses both thresholds, both with and without grants. A bench model applies clear-then-set ordering, and every cycle it compares the pending word, vector and stack state against the design.

// File: rtl/icu_pkg.sv
package icu_pkg;
    // Fixed roles of the most urgent sources (index = priority = vector)
    localparam int SRC_RESET  = 0;
    localparam int SRC_PWRDN  = 1;
    localparam int SRC_EMU    = 2;
    localparam int SRC_STKLVL = 3;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_GRANT = 2'd1,
        OP_POP   = 2'd2,
        OP_PUSH  = 2'd3
    } stk_op_e;
endpackage

// File: rtl/icu_pending.sv
module icu_pending
    import icu_pkg::*;
#(
    parameter int NUM_SRC = 13,
    parameter int LVLW    = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] req,
    input  logic [NUM_SRC-1:0] sw_set,
    input  logic [NUM_SRC-1:0] sw_clr,
    input  logic               grant,
    input  logic [LVLW-1:0]    grant_idx,
    input  logic               wm_set,
    output logic [NUM_SRC-1:0] pend
);
    logic [NUM_SRC-1:0] clr_vec, set_vec, pend_nxt;

    always_comb begin
        clr_vec = sw_clr;
        if (grant) clr_vec[grant_idx] = 1'b1;
        set_vec = req | sw_set;
        if (wm_set) set_vec[SRC_STKLVL] = 1'b1;
        // clearing applies first, so any set in the same cycle survives
        pend_nxt = (pend & ~clr_vec) | set_vec;
    end

    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= pend_nxt;
    end
endmodule

// File: rtl/icu_select.sv
module icu_select
    import icu_pkg::*;
#(
    parameter int NUM_SRC = 13,
    parameter int LVLW    = 4
) (
    input  logic [NUM_SRC-1:0] pend,
    input  logic [NUM_SRC-1:0] mask,
    input  logic               gie,
    input  logic               nest_en,
    input  logic [LVLW-1:0]    active,
    input  logic               stack_full,
    output logic               valid,
    output logic [LVLW-1:0]    vec
);
    logic [NUM_SRC-1:0] nmi, elig;
    logic               found, idle, allow;
    logic [LVLW-1:0]    pick;

    always_comb begin
        nmi = '0;
        nmi[SRC_RESET] = 1'b1;
        nmi[SRC_PWRDN] = 1'b1;
        nmi[SRC_EMU]   = 1'b1;
        if (gie) begin
            elig = pend & (mask | nmi);
        end else begin
            elig = pend & nmi;
            elig[SRC_PWRDN] = 1'b0;
        end
        found = 1'b0;
        pick  = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (elig[i]) begin
                found = 1'b1;
                pick  = LVLW'(i);
            end
        end
        idle  = (active == LVLW'(NUM_SRC));
        allow = idle || (nest_en && (pick < active));
        valid = found && allow && !stack_full;
        vec   = pick;
    end
endmodule

// File: rtl/icu_stack.sv
module icu_stack
    import icu_pkg::*;
#(
    parameter int DEPTH     = 33,
    parameter int LVLW      = 4,
    parameter int FILLW     = 6,
    parameter int LOW_MARK  = 3,
    parameter int HIGH_MARK = 28,
    parameter int IDLE_LVL  = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  stk_op_e          op,
    input  logic [LVLW-1:0]  new_lvl,
    output logic [LVLW-1:0]  active,
    output logic [FILLW-1:0] fill,
    output logic             full,
    output logic             wm_evt
);
    logic [LVLW-1:0]  mem [DEPTH];
    logic [FILLW-1:0] fill_nxt;
    logic             do_save, do_restore;

    assign full = (fill == FILLW'(DEPTH));

    always_comb begin
        do_save    = ((op == OP_GRANT) || (op == OP_PUSH)) && !full;
        do_restore = (op == OP_POP) && (fill != '0);
        fill_nxt   = fill;
        if (do_save)    fill_nxt = fill + 1'b1;
        if (do_restore) fill_nxt = fill - 1'b1;
        wm_evt = ((fill >= FILLW'(LOW_MARK))  && (fill_nxt <  FILLW'(LOW_MARK))) ||
                 ((fill <= FILLW'(HIGH_MARK)) && (fill_nxt >  FILLW'(HIGH_MARK)));
    end

    always_ff @(posedge clk) begin
        if (do_save) mem[fill] <= active;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= LVLW'(IDLE_LVL);
            fill   <= '0;
        end else begin
            fill <= fill_nxt;
            if (do_save && (op == OP_GRANT)) active <= new_lvl;
            else if (do_restore)             active <= mem[fill - 1'b1];
        end
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import icu_pkg::*;
#(
    parameter int NUM_SRC   = 13,
    parameter int DEPTH     = 33,
    parameter int LOW_MARK  = 3,
    parameter int HIGH_MARK = 28,
    localparam int LVLW     = $clog2(NUM_SRC + 1),
    localparam int FILLW    = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic               mask_we,
    input  logic [NUM_SRC-1:0] mask_wdata,
    input  logic [NUM_SRC-1:0] pend_set,
    input  logic [NUM_SRC-1:0] pend_clr,
    input  logic               gie_on,
    input  logic               gie_off,
    input  logic               nest_en,
    input  logic               ack,
    input  logic               push,
    input  logic               pop,
    output logic               irq_valid,
    output logic [LVLW-1:0]    irq_vec,
    output logic [NUM_SRC-1:0] mask_q,
    output logic [NUM_SRC-1:0] pend_q,
    output logic               gie_q,
    output logic [LVLW-1:0]    active_q,
    output logic [FILLW-1:0]   stack_fill
);
    logic    grant, full, wm_evt;
    stk_op_e op;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            gie_q  <= 1'b0;
        end else begin
            if (mask_we) mask_q <= mask_wdata;
            if (gie_off)     gie_q <= 1'b0;
            else if (gie_on) gie_q <= 1'b1;
        end
    end

    assign grant = ack && irq_valid;

    always_comb begin
        if (grant)     op = OP_GRANT;
        else if (pop)  op = OP_POP;
        else if (push) op = OP_PUSH;
        else           op = OP_NONE;
    end

    icu_pending #(.NUM_SRC(NUM_SRC), .LVLW(LVLW)) u_pend (
        .clk(clk), .rst(rst), .req(irq_req), .sw_set(pend_set), .sw_clr(pend_clr),
        .grant(grant), .grant_idx(irq_vec), .wm_set(wm_evt), .pend(pend_q)
    );

    icu_select #(.NUM_SRC(NUM_SRC), .LVLW(LVLW)) u_sel (
        .pend(pend_q), .mask(mask_q), .gie(gie_q), .nest_en(nest_en),
        .active(active_q), .stack_full(full), .valid(irq_valid), .vec(irq_vec)
    );

    icu_stack #(
        .DEPTH(DEPTH), .LVLW(LVLW), .FILLW(FILLW), .LOW_MARK(LOW_MARK),
        .HIGH_MARK(HIGH_MARK), .IDLE_LVL(NUM_SRC)
    ) u_stk (
        .clk(clk), .rst(rst), .op(op), .new_lvl(irq_vec), .active(active_q),
        .fill(stack_fill), .full(full), .wm_evt(wm_evt)
    );
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
    parameter int NUM_SRC   = 13,
    parameter int DEPTH     = 33,
    parameter int LOW_MARK  = 3,
    parameter int LVLW      = 4,
    parameter int FILLW     = 6
) (
    input logic               clk,
    input logic               rst,
    input logic               gie_off,
    input logic               nest_en,
    input logic               ack,
    input logic               pop,
    input logic               irq_valid,
    input logic [LVLW-1:0]    irq_vec,
    input logic [NUM_SRC-1:0] pend_q,
    input logic               gie_q,
    input logic [LVLW-1:0]    active_q,
    input logic [FILLW-1:0]   stack_fill
);
    localparam logic [LVLW-1:0] IDLE = LVLW'(NUM_SRC);

    a_r6_vec_range: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> (irq_vec < LVLW'(NUM_SRC)));

    a_r5_gie_off_only_nmi: assert property (@(posedge clk) disable iff (rst)
        (irq_valid && !gie_q) |-> ((irq_vec == 0) || (irq_vec == 2)));

    a_r7_off_strobe: assert property (@(posedge clk) disable iff (rst)
        gie_off |=> !gie_q);

    a_r8_run_to_end: assert property (@(posedge clk) disable iff (rst)
        (!nest_en && (active_q != IDLE)) |-> !irq_valid);

    a_r9_strictly_higher: assert property (@(posedge clk) disable iff (rst)
        (irq_valid && (active_q != IDLE)) |-> (irq_vec < active_q));

    a_r10_grant_enters: assert property (@(posedge clk) disable iff (rst)
        (ack && irq_valid) |=> ((active_q == $past(irq_vec)) &&
                                (stack_fill == $past(stack_fill) + 1'b1)));

    a_r11_pop_lowers: assert property (@(posedge clk) disable iff (rst)
        (pop && !(ack && irq_valid) && (stack_fill != '0)) |=>
            (stack_fill == $past(stack_fill) - 1'b1));

    a_r11_fill_bound: assert property (@(posedge clk) disable iff (rst)
        stack_fill <= FILLW'(DEPTH));

    a_r12_low_crossing: assert property (@(posedge clk) disable iff (rst)
        ((stack_fill == FILLW'(LOW_MARK)) && pop && !(ack && irq_valid)) |=> pend_q[3]);
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(
    .NUM_SRC(NUM_SRC), .DEPTH(DEPTH), .LOW_MARK(LOW_MARK), .LVLW(LVLW), .FILLW(FILLW)
) u_chk (
    .clk(clk), .rst(rst), .gie_off(gie_off), .nest_en(nest_en), .ack(ack), .pop(pop),
    .irq_valid(irq_valid), .irq_vec(irq_vec), .pend_q(pend_q), .gie_q(gie_q),
    .active_q(active_q), .stack_fill(stack_fill)
);

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;
    localparam int N = 13;
    localparam int D = 33;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [N-1:0] irq_req = '0, mask_wdata = '0, pend_set = '0, pend_clr = '0;
    logic mask_we = 0, gie_on = 0, gie_off = 0, nest_en = 0, ack = 0, push = 0, pop = 0;
    logic irq_valid, gie_q;
    logic [3:0] irq_vec, active_q;
    logic [N-1:0] mask_q, pend_q;
    logic [5:0] stack_fill;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // bench model of the controller state
    logic [N-1:0] m_pend, m_mask;
    bit m_gie;
    int m_active, m_fill;
    int m_stk [D];

    always #5 clk = ~clk;

    irq_prio_ctrl u_irq_prio_ctrl (
        .clk(clk), .rst(rst), .irq_req(irq_req), .mask_we(mask_we), .mask_wdata(mask_wdata),
        .pend_set(pend_set), .pend_clr(pend_clr), .gie_on(gie_on), .gie_off(gie_off),
        .nest_en(nest_en), .ack(ack), .push(push), .pop(pop), .irq_valid(irq_valid),
        .irq_vec(irq_vec), .mask_q(mask_q), .pend_q(pend_q), .gie_q(gie_q),
        .active_q(active_q), .stack_fill(stack_fill)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // expected presented vector, -1 when nothing may be granted
    function automatic int exp_vec();
        logic [N-1:0] e;
        int f = -1;
        if (m_gie) e = m_pend & (m_mask | 13'b0_0000_0000_0111);
        else       e = m_pend & 13'b0_0000_0000_0101;
        for (int i = N - 1; i >= 0; i--) if (e[i]) f = i;
        if (f < 0 || m_fill == D) return -1;
        if (m_active == N) return f;
        if (nest_en && f < m_active) return f;
        return -1;
    endfunction

    function automatic logic [N-1:0] sparse(input int odds);
        logic [N-1:0] v;
        for (int i = 0; i < N; i++) v[i] = ($urandom % odds) == 0;
        return v;
    endfunction

    // compare outputs with the model after the new inputs settle, then advance it
    task automatic cycle();
        int v, old_fill;
        bit grant, wm;
        logic [N-1:0] clr;
        string vtag, stag;
        #1;
        v = exp_vec();
        if (!m_gie) vtag = "R5";
        else if (m_active != N && nest_en) vtag = "R9";
        else if (m_active != N) vtag = "R8";
        else vtag = "R6";
        chk({vtag, " valid"}, int'(irq_valid), int'(v >= 0));
        if (v >= 0) chk({vtag, " vector"}, int'(irq_vec), v);

        grant = ack && (v >= 0);
        clr = pend_clr;
        if (grant) clr[v] = 1'b1;
        old_fill = m_fill;
        stag = "R11";
        if (grant) begin
            m_stk[m_fill] = m_active; m_active = v; m_fill++; stag = "R10";
        end else if (pop) begin
            if (m_fill > 0) begin m_fill--; m_active = m_stk[m_fill]; end
        end else if (push) begin
            if (m_fill < D) begin m_stk[m_fill] = m_active; m_fill++; end
        end
        wm = (old_fill >= 3 && m_fill < 3) || (old_fill <= 28 && m_fill > 28);
        m_pend = (m_pend & ~clr) | irq_req | pend_set;
        if (wm) m_pend[3] = 1'b1;
        if (mask_we) m_mask = mask_wdata;
        if (gie_off) m_gie = 0; else if (gie_on) m_gie = 1;

        @(posedge clk);
        @(negedge clk);
        chk(wm ? "R12 pending" : ((pend_set | pend_clr) != 0 ? "R3 pending" : "R2 pending"),
            int'(pend_q), int'(m_pend));
        chk("R4 mask", int'(mask_q), int'(m_mask));
        chk("R7 enable", int'(gie_q), int'(m_gie));
        chk({stag, " level"}, int'(active_q), m_active);
        chk({stag, " fill"}, int'(stack_fill), m_fill);
    endtask

    task automatic quiet();
        irq_req = '0; pend_set = '0; pend_clr = '0; mask_we = 0;
        gie_on = 0; gie_off = 0; ack = 0; push = 0; pop = 0;
    endtask

    task automatic rand_inputs(input int ack_odds, input int push_odds, input int pop_odds);
        irq_req  = sparse(16);
        pend_set = sparse(40);
        pend_clr = sparse(12);
        mask_we  = ($urandom % 20) == 0;
        mask_wdata = N'($urandom);
        gie_on   = ($urandom % 10) == 0;
        gie_off  = ($urandom % 25) == 0;
        if (($urandom % 100) == 0) nest_en = ~nest_en;
        ack  = ($urandom % ack_odds) == 0;
        push = ($urandom % push_odds) == 0;
        pop  = ($urandom % pop_odds) == 0;
    endtask

    initial begin
        void'($urandom(32'd7321));
        m_pend = '0; m_mask = '0; m_gie = 0; m_active = N; m_fill = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: state right after reset
        chk("R1 pending", int'(pend_q), 0);
        chk("R1 mask", int'(mask_q), 0);
        chk("R1 enable", int'(gie_q), 0);
        chk("R1 level", int'(active_q), N);
        chk("R1 fill", int'(stack_fill), 0);
        chk("R1 valid", int'(irq_valid), 0);

        // directed R5: power-down blocked with enable off, emulation not
        quiet(); pend_set = 13'b0_0000_0000_0010; cycle();
        quiet(); cycle();
        quiet(); pend_set = 13'b0_0000_0000_0100; cycle();
        quiet(); ack = 1; cycle();
        quiet(); pop = 1; cycle();
        // directed R7: both strobes, off wins
        quiet(); gie_on = 1; gie_off = 1; cycle();
        quiet(); gie_on = 1; cycle();
        // directed R3: same-bit set and clear
        quiet(); pend_set = 13'b1_0000_0000_0000; pend_clr = 13'b1_0000_0000_0000; cycle();

        for (int k = 0; k < 6000; k++) begin
            rand_inputs(2, 8, 5);
            cycle();
        end
        // directed R11/R12: fill to full and beyond, then drain past empty
        for (int k = 0; k < 36; k++) begin
            quiet(); push = 1; ack = (k % 7) == 3; cycle();
        end
        for (int k = 0; k < 38; k++) begin
            quiet(); pop = 1; ack = (k % 9) == 4; pend_clr = (k % 5 == 0) ? 13'h8 : '0; cycle();
        end
        for (int k = 0; k < 4000; k++) begin
            rand_inputs(3, 4, 9);
            cycle();
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule